// File: doc/BRIEF.md
# Shadowed dual compare-event generator

This block runs a 16-bit time-base counter and compares it each cycle against two compare channels, A and B. When the counter equals a channel's active compare value, the block raises a one-cycle event for that channel. A downstream stage turns these events into output levels. Each event carries a flag that says whether the counter was counting down at the time. In up-down counting this flag tells the two matches of one cycle apart.

The counter has four modes: up, down, up-down and hold. It is enabled by `run` and bounded by a programmable period. Each channel holds an active compare value and a shadow value. Both sit behind one write address and one readback address. A control word sets, per channel, one of two modes:
- **Immediate:** writes and reads go straight to the active value.
- **Shadowed:** writes and reads use the shadow, and the shadow is copied to the active value at a chosen counter boundary: zero, period, or either.

The time base is a three-state machine: `TB_IDLE`, `TB_UP` and `TB_DOWN`. Its transitions are:
- **idle→up/down:** `run` is high and the mode is not hold.
- **any→idle:** `run` is low or the mode is hold.
- **up→down (up-down mode only):** the counter reaches the period with a non-zero period.
- **down→up (up-down mode only):** the counter reaches zero.

In plain up mode the machine stays in `TB_UP`. In plain down mode it stays in `TB_DOWN`.

Top module: `cmp_event_gen`

## Requirements
- R1: After reset the counter is 0, the machine is idle, every shadow and active value is 0, and readback returns 0 for both channels.
- R2: In up mode (`count_mode`=00) with `run` high, the counter goes up by one each cycle while below the period, and returns to 0 on the cycle after it equals or exceeds the period. `cnt_dn` is low.
- R3: In down mode (`count_mode`=01) the counter goes down by one each cycle, and reloads the period on the cycle after it is 0 or above the period. `cnt_dn` is high.
- R4: In up-down mode (`count_mode`=10) the counter rises to the period and then falls to 0, with `cnt_dn` high while falling. A compare value strictly between 0 and the period gives two events per full cycle, one with the down flag low and one with it high. A value of 0 or of the period gives one event.
- R5: A channel's event is high exactly when the machine is counting, the counter equals that channel's active value, and that value is not above the period. A value above the period never gives an event. The down flag is high only together with its event.
- R6: In shadowed mode (control bit 0 for A, bit 1 for B, value 0), a write with `wr_sel` (0=A, 1=B) updates only the shadow, and readback returns the shadow.
- R7: In shadowed mode, the shadow is copied to the active value at a clock edge where the counting counter meets the load condition in the channel's 2-bit load field (bits 3:2 for A, 5:4 for B): 00 means counter is 0, 01 means counter equals the period, 10 means either, and 11 means never.
- R8: In immediate mode (control bit 1), a write updates the active value at the next edge, readback returns the active value, and no shadow transfer takes place.
- R9: If a shadow write and a load event occur in the same cycle, the active value takes the previous shadow content. The written value stays in the shadow for the next load.
- R10: When `run` is low or `count_mode` is 11, the counter holds its value, no events are produced and no shadow transfer occurs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run | input | 1 | Counter enable |
| count_mode | input | 2 | 00 up, 01 down, 10 up-down, 11 hold |
| period | input | 16 | Counter period |
| ctl | input | 6 | {B load field, A load field, B immediate, A immediate} |
| wr_en | input | 1 | Compare write strobe |
| wr_sel | input | 1 | Write channel, 0=A, 1=B |
| wr_data | input | 16 | Compare write value |
| rd_sel | input | 1 | Readback channel, 0=A, 1=B |
| rd_data | output | 16 | Shadow (shadowed mode) or active (immediate mode) value |
| cnt | output | 16 | Time-base counter |
| cnt_dn | output | 1 | Counter is counting down |
| evt_a | output | 1 | Counter matches active A |
| evt_a_dn | output | 1 | A match occurred while counting down |
| evt_b | output | 1 | Counter matches active B |
| evt_b_dn | output | 1 | B match occurred while counting down |

## Verification
A software write to a channel's shadow and that channel's load event can fall on the same clock edge. The bench provokes this by advancing its own counter model until the counter sits at the load boundary, and then issuing the shadow write in exactly that cycle. The result is judged in two ways. The readback must show the newly written value at once. The events must keep firing at the value held in the shadow before the write, until the next load boundary moves the new value into the active register.

// File: rtl/cmp_evt_pkg.sv
package cmp_evt_pkg;

    typedef enum logic [1:0] {
        TB_IDLE = 2'd0,
        TB_UP   = 2'd1,
        TB_DOWN = 2'd2
    } tb_state_e;

    typedef enum logic [1:0] {
        CM_UP     = 2'd0,
        CM_DOWN   = 2'd1,
        CM_UPDOWN = 2'd2,
        CM_HOLD   = 2'd3
    } cnt_mode_e;

    typedef enum logic [1:0] {
        LD_ZERO   = 2'd0,
        LD_PERIOD = 2'd1,
        LD_EITHER = 2'd2,
        LD_NONE   = 2'd3
    } ld_mode_e;

    // Decide whether a shadow-to-active transfer happens this cycle
    function automatic logic load_hit(ld_mode_e mode, logic at_zero, logic at_prd);
        logic hit;
        unique case (mode)
            LD_ZERO:   hit = at_zero;
            LD_PERIOD: hit = at_prd;
            LD_EITHER: hit = at_zero | at_prd;
            default:   hit = 1'b0;
        endcase
        return hit;
    endfunction

endpackage

// File: rtl/cmp_timebase.sv
module cmp_timebase
    import cmp_evt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [1:0]       count_mode,
    input  logic [CNT_W-1:0] period,
    output logic [CNT_W-1:0] cnt,
    output logic             running,
    output logic             dir_dn,
    output logic             at_zero,
    output logic             at_prd
);

    tb_state_e        st_q, st_nxt;
    logic [CNT_W-1:0] cnt_q, cnt_nxt;
    cnt_mode_e        mode_e;
    logic             go;
    logic             prd_zero;

    assign mode_e   = cnt_mode_e'(count_mode);
    assign go       = run && (mode_e != CM_HOLD);
    assign prd_zero = (period == '0);

    // State and counter register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= TB_IDLE;
            cnt_q <= '0;
        end else begin
            st_q  <= st_nxt;
            cnt_q <= cnt_nxt;
        end
    end

    // Transition logic
    always_comb begin
        st_nxt  = st_q;
        cnt_nxt = cnt_q;
        if (!go) begin
            st_nxt = TB_IDLE;
        end else begin
            unique case (mode_e)
                CM_UP: begin
                    st_nxt  = TB_UP;
                    cnt_nxt = (cnt_q >= period) ? '0 : cnt_q + 1'b1;
                end
                CM_DOWN: begin
                    st_nxt  = TB_DOWN;
                    cnt_nxt = ((cnt_q == '0) || (cnt_q > period)) ? period : cnt_q - 1'b1;
                end
                CM_UPDOWN: begin
                    if (st_q == TB_DOWN) begin
                        if (cnt_q == '0) begin
                            st_nxt  = TB_UP;
                            cnt_nxt = prd_zero ? '0 : {{(CNT_W-1){1'b0}}, 1'b1};
                        end else begin
                            st_nxt  = TB_DOWN;
                            cnt_nxt = cnt_q - 1'b1;
                        end
                    end else begin
                        if (cnt_q >= period) begin
                            st_nxt  = prd_zero ? TB_UP : TB_DOWN;
                            cnt_nxt = prd_zero ? '0 : period - 1'b1;
                        end else begin
                            st_nxt  = TB_UP;
                            cnt_nxt = cnt_q + 1'b1;
                        end
                    end
                end
                default: begin
                    st_nxt = TB_IDLE;
                end
            endcase
        end
    end

    // Outputs decoded from the state
    always_comb begin
        unique case (st_q)
            TB_UP: begin
                running = 1'b1;
                dir_dn  = 1'b0;
            end
            TB_DOWN: begin
                running = 1'b1;
                dir_dn  = 1'b1;
            end
            default: begin
                running = 1'b0;
                dir_dn  = 1'b0;
            end
        endcase
        cnt     = cnt_q;
        at_zero = running && (cnt_q == '0);
        at_prd  = running && (cnt_q == period);
    end

endmodule

// File: rtl/cmp_evt_channel.sv
module cmp_evt_channel
    import cmp_evt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             imm,
    input  logic [1:0]       ld_mode,
    input  logic             wr_en,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             running,
    input  logic             at_zero,
    input  logic             at_prd,
    input  logic             dir_dn,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] period,
    output logic [CNT_W-1:0] act_val,
    output logic [CNT_W-1:0] shd_val,
    output logic [CNT_W-1:0] rd_val,
    output logic             evt,
    output logic             evt_dn
);

    logic [CNT_W-1:0] act_q, shd_q;
    logic             xfer;

    assign xfer = load_hit(ld_mode_e'(ld_mode), at_zero, at_prd);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q <= '0;
            shd_q <= '0;
        end else if (imm) begin
            if (wr_en) act_q <= wr_data;
        end else begin
            // transfer uses the shadow content from before any write this cycle
            if (xfer)  act_q <= shd_q;
            if (wr_en) shd_q <= wr_data;
        end
    end

    always_comb begin
        evt     = running && (cnt == act_q) && (act_q <= period);
        evt_dn  = evt && dir_dn;
        rd_val  = imm ? act_q : shd_q;
        act_val = act_q;
        shd_val = shd_q;
    end

endmodule

// File: rtl/cmp_event_gen.sv
module cmp_event_gen #(
    parameter int CNT_W  = 16,
    parameter int NUM_CH = 2,
    localparam int CTL_W = NUM_CH * 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [1:0]       count_mode,
    input  logic [CNT_W-1:0] period,
    input  logic [CTL_W-1:0] ctl,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             rd_sel,
    output logic [CNT_W-1:0] rd_data,
    output logic [CNT_W-1:0] cnt,
    output logic             cnt_dn,
    output logic             evt_a,
    output logic             evt_a_dn,
    output logic             evt_b,
    output logic             evt_b_dn
);

    logic                        running, at_zero, at_prd;
    logic [NUM_CH-1:0][CNT_W-1:0] act_v, shd_v, rd_v;
    logic [NUM_CH-1:0]            evt_v, evt_dn_v;

    cmp_timebase #(.CNT_W(CNT_W)) u_tb (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (run),
        .count_mode (count_mode),
        .period     (period),
        .cnt        (cnt),
        .running    (running),
        .dir_dn     (cnt_dn),
        .at_zero    (at_zero),
        .at_prd     (at_prd)
    );

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        cmp_evt_channel #(.CNT_W(CNT_W)) u_ch (
            .clk     (clk),
            .rst_n   (rst_n),
            .imm     (ctl[ch]),
            .ld_mode (ctl[NUM_CH + 2*ch +: 2]),
            .wr_en   (wr_en && (wr_sel == 1'(ch))),
            .wr_data (wr_data),
            .running (running),
            .at_zero (at_zero),
            .at_prd  (at_prd),
            .dir_dn  (cnt_dn),
            .cnt     (cnt),
            .period  (period),
            .act_val (act_v[ch]),
            .shd_val (shd_v[ch]),
            .rd_val  (rd_v[ch]),
            .evt     (evt_v[ch]),
            .evt_dn  (evt_dn_v[ch])
        );
    end

    assign rd_data  = rd_v[rd_sel];
    assign evt_a    = evt_v[0];
    assign evt_a_dn = evt_dn_v[0];
    assign evt_b    = evt_v[1];
    assign evt_b_dn = evt_dn_v[1];

endmodule

// File: rtl/cmp_event_gen_chk.sv
module cmp_event_gen_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             run,
    input logic [1:0]       count_mode,
    input logic [CNT_W-1:0] period,
    input logic             imm_a,
    input logic             wr_en,
    input logic             wr_sel,
    input logic [CNT_W-1:0] wr_data,
    input logic [CNT_W-1:0] cnt,
    input logic             cnt_dn,
    input logic             evt_a,
    input logic             evt_a_dn,
    input logic             evt_b,
    input logic             evt_b_dn,
    input logic [CNT_W-1:0] act_a,
    input logic [CNT_W-1:0] shd_a
);

    AST_UP_INC: assert property (@(posedge clk) disable iff (!rst_n)
        (run && count_mode == 2'b00 && cnt < period) |=> (cnt == $past(cnt) + 1'b1)); // R2

    AST_UP_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (run && count_mode == 2'b00 && cnt >= period) |=> (cnt == '0)); // R2

    AST_DN_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (run && count_mode == 2'b01 && cnt == '0) |=> (cnt == $past(period) && cnt_dn)); // R3

    AST_UD_TURN: assert property (@(posedge clk) disable iff (!rst_n)
        (run && count_mode == 2'b10 && period != '0 && cnt == period) |=> cnt_dn); // R4

    AST_DN_FLAG_A: assert property (@(posedge clk) disable iff (!rst_n)
        evt_a_dn |-> evt_a); // R5

    AST_DN_FLAG_B: assert property (@(posedge clk) disable iff (!rst_n)
        evt_b_dn |-> evt_b); // R5

    AST_EVT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        evt_a |-> (act_a <= period)); // R5

    AST_SHD_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_sel && !imm_a) |=> (shd_a == $past(wr_data))); // R6

    AST_IMM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_sel && imm_a) |=> (act_a == $past(wr_data))); // R8

    AST_HOLD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!run || count_mode == 2'b11) |=> ($stable(cnt) && !evt_a && !evt_b)); // R10

endmodule

bind cmp_event_gen cmp_event_gen_chk #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (run),
    .count_mode (count_mode),
    .period     (period),
    .imm_a      (ctl[0]),
    .wr_en      (wr_en),
    .wr_sel     (wr_sel),
    .wr_data    (wr_data),
    .cnt        (cnt),
    .cnt_dn     (cnt_dn),
    .evt_a      (evt_a),
    .evt_a_dn   (evt_a_dn),
    .evt_b      (evt_b),
    .evt_b_dn   (evt_b_dn),
    .act_a      (act_v[0]),
    .shd_a      (shd_v[0])
);

// File: tb/sim_cmp_event_gen.sv
module sim_cmp_event_gen;

    localparam int CLK_PERIOD = 10;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         run = 1'b0;
    logic [1:0]   count_mode = 2'b00;
    logic [W-1:0] period = '0;
    logic [5:0]   ctl = '0;
    logic         wr_en = 1'b0;
    logic         wr_sel = 1'b0;
    logic [W-1:0] wr_data = '0;
    logic         rd_sel = 1'b0;
    logic [W-1:0] rd_data, cnt;
    logic         cnt_dn, evt_a, evt_a_dn, evt_b, evt_b_dn;

    cmp_event_gen u0 (
        .clk(clk), .rst_n(rst_n), .run(run), .count_mode(count_mode),
        .period(period), .ctl(ctl), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data), .cnt(cnt),
        .cnt_dn(cnt_dn), .evt_a(evt_a), .evt_a_dn(evt_a_dn),
        .evt_b(evt_b), .evt_b_dn(evt_b_dn)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // stimulus values applied at the next falling edge
    logic         d_run = 1'b0;
    logic [1:0]   d_mode = 2'b00;
    logic [W-1:0] d_period = '0;
    logic [5:0]   d_ctl = '0;
    logic         d_wr_en = 1'b0;
    logic         d_wr_sel = 1'b0;
    logic [W-1:0] d_wr_data = '0;
    logic         d_rd_sel = 1'b0;

    // reference model state
    int           m_state = 0;   // 0 idle, 1 up, 2 down
    logic [W-1:0] m_cnt = '0;
    logic [W-1:0] m_act [2];
    logic [W-1:0] m_shd [2];

    typedef struct packed {
        logic [W-1:0] cnt;
        logic         dn;
        logic         ea, ead, eb, ebd;
        logic [W-1:0] rd;
    } exp_t;
    exp_t q[$];

    int    n_tests = 0;
    int    n_fail = 0;
    bit    done = 1'b0;
    string cur_req = "R1";
    int    n_a_up = 0, n_a_dn = 0, n_b = 0;
    logic [W-1:0] last_rd, last_cnt;

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    function automatic bit ld_sel(logic [1:0] m, bit z, bit p);
        case (m)
            2'b00:   return z;
            2'b01:   return p;
            2'b10:   return z | p;
            default: return 1'b0;
        endcase
    endfunction

    function automatic exp_t model_out();
        exp_t e;
        bit   running = (m_state != 0);
        int   s = d_rd_sel;
        e.cnt = m_cnt;
        e.dn  = (m_state == 2);
        e.ea  = running && (m_cnt == m_act[0]) && (m_act[0] <= d_period);
        e.ead = e.ea && (m_state == 2);
        e.eb  = running && (m_cnt == m_act[1]) && (m_act[1] <= d_period);
        e.ebd = e.eb && (m_state == 2);
        e.rd  = d_ctl[s] ? m_act[s] : m_shd[s];
        return e;
    endfunction

    task automatic model_edge();
        bit running = (m_state != 0);
        bit z = running && (m_cnt == 0);
        bit p = running && (m_cnt == d_period);
        for (int ch = 0; ch < 2; ch++) begin
            bit         wr = d_wr_en && (d_wr_sel == ch[0]);
            logic [1:0] lm = (ch == 0) ? d_ctl[3:2] : d_ctl[5:4];
            if (d_ctl[ch]) begin
                if (wr) m_act[ch] = d_wr_data;
            end else begin
                if (ld_sel(lm, z, p)) m_act[ch] = m_shd[ch];
                if (wr) m_shd[ch] = d_wr_data;
            end
        end
        if (!d_run || d_mode == 2'b11) begin
            m_state = 0;
        end else if (d_mode == 2'b00) begin
            m_state = 1;
            m_cnt   = (m_cnt >= d_period) ? '0 : m_cnt + 1'b1;
        end else if (d_mode == 2'b01) begin
            m_state = 2;
            m_cnt   = (m_cnt == 0 || m_cnt > d_period) ? d_period : m_cnt - 1'b1;
        end else if (m_state == 2) begin
            if (m_cnt == 0) begin
                m_state = 1;
                m_cnt   = (d_period == 0) ? '0 : W'(1);
            end else begin
                m_cnt = m_cnt - 1'b1;
            end
        end else begin
            if (m_cnt >= d_period) begin
                m_state = (d_period == 0) ? 1 : 2;
                m_cnt   = (d_period == 0) ? '0 : d_period - 1'b1;
            end else begin
                m_state = 1;
                m_cnt   = m_cnt + 1'b1;
            end
        end
    endtask

    // driver: one clock cycle, expected outputs pushed to the scoreboard
    task automatic step();
        @(negedge clk);
        run = d_run; count_mode = d_mode; period = d_period; ctl = d_ctl;
        wr_en = d_wr_en; wr_sel = d_wr_sel; wr_data = d_wr_data; rd_sel = d_rd_sel;
        q.push_back(model_out());
        @(posedge clk);
        model_edge();
    endtask

    task automatic steps(int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic write(bit sel, logic [W-1:0] val);
        d_wr_en = 1'b1; d_wr_sel = sel; d_wr_data = val;
        step();
        d_wr_en = 1'b0;
    endtask

    task automatic clear_counts();
        n_a_up = 0; n_a_dn = 0; n_b = 0;
    endtask

    // monitor: compare design outputs to scoreboard entries
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                chk(cur_req, "cnt", cnt, e.cnt);
                chk(cur_req, "cnt_dn", cnt_dn, e.dn);
                chk(cur_req, "evt_a", evt_a, e.ea);
                chk(cur_req, "evt_a_dn", evt_a_dn, e.ead);
                chk(cur_req, "evt_b", evt_b, e.eb);
                chk(cur_req, "evt_b_dn", evt_b_dn, e.ebd);
                chk(cur_req, "rd_data", rd_data, e.rd);
                if (evt_a && !evt_a_dn) n_a_up++;
                if (evt_a_dn) n_a_dn++;
                if (evt_b) n_b++;
                last_rd  = rd_data;
                last_cnt = cnt;
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired act=1 exp=0");
        finish_run();
    end

    initial begin
        logic [W-1:0] held;
        m_act[0] = '0; m_act[1] = '0; m_shd[0] = '0; m_shd[1] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state on both readback channels
        cur_req = "R1";
        d_rd_sel = 1'b0; step();
        chk("R1", "rd A after reset", last_rd, 0);
        d_rd_sel = 1'b1; step();
        chk("R1", "rd B after reset", last_rd, 0);
        chk("R1", "cnt after reset", last_cnt, 0);

        // R6: shadow writes while idle, readback shows shadow
        cur_req = "R6";
        d_ctl = 6'b000000;
        write(1'b0, 16'd3);
        write(1'b1, 16'd5);
        d_rd_sel = 1'b0; step();
        chk("R6", "rd A shadow", last_rd, 3);

        // R2: up counting, load at zero
        cur_req = "R2";
        d_period = 16'd7; d_mode = 2'b00; d_run = 1'b1;
        steps(20);

        // R7: load at period for A, at either for B, then never for A
        cur_req = "R7";
        d_ctl = 6'b100100;
        write(1'b0, 16'd6);
        write(1'b1, 16'd2);
        steps(20);
        d_ctl = 6'b101100;
        write(1'b0, 16'd1);
        clear_counts();
        steps(16);
        chk("R7", "A events with load field 11 (still at 6)", n_a_up, 2);

        // R3: down counting
        cur_req = "R3";
        d_mode = 2'b01;
        steps(20);

        // R4: up-down counting, A inside range, B at the period
        cur_req = "R4";
        d_ctl = 6'b000000; d_mode = 2'b10;
        write(1'b0, 16'd3);
        write(1'b1, 16'd7);
        steps(16);
        while (!(m_state == 2 && m_cnt == 0)) step();
        clear_counts();
        steps(14);
        chk("R4", "A up events per cycle", n_a_up, 1);
        chk("R4", "A down events per cycle", n_a_dn, 1);
        chk("R4", "B events at period", n_b, 1);
        write(1'b1, 16'd0);
        steps(16);
        while (!(m_state == 2 && m_cnt == 0)) step();
        clear_counts();
        steps(14);
        chk("R4", "B events at zero", n_b, 1);

        // R5: compare value above the period
        cur_req = "R5";
        write(1'b0, 16'd9);
        steps(16);
        clear_counts();
        steps(16);
        chk("R5", "A events above period", n_a_up + n_a_dn, 0);

        // R8: immediate mode on A
        cur_req = "R8";
        d_mode = 2'b00; d_ctl = 6'b000001; d_rd_sel = 1'b0;
        write(1'b0, 16'd2);
        step();
        chk("R8", "rd A immediate", last_rd, 2);
        steps(12);

        // R9: shadow write on the load edge
        cur_req = "R9";
        d_ctl = 6'b000000;
        write(1'b0, 16'd5);
        while (!(m_state != 0 && m_cnt == 0)) step();
        write(1'b0, 16'd6);
        step();
        chk("R9", "rd A keeps new shadow", last_rd, 6);
        while (m_cnt != 16'd4) step();
        clear_counts();
        steps(2);
        chk("R9", "A event at previous shadow value", n_a_up, 1);
        steps(12);

        // R10: run low, then hold mode
        cur_req = "R10";
        d_run = 1'b0;
        step();
        held = last_cnt;
        clear_counts();
        steps(8);
        chk("R10", "cnt held with run low", last_cnt, held);
        d_run = 1'b1; d_mode = 2'b11;
        steps(8);
        chk("R10", "cnt held in hold mode", last_cnt, held);
        chk("R10", "no events while holding", n_a_up + n_a_dn + n_b, 0);

        step();
        finish_run();
    end

endmodule